// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block decides whether an address arriving from the external bus falls into one of three programmable inbound memory windows, and if so, which window it hit and what local address it maps to. Each window is set by one 32-bit configuration word: the upper twelve bits give a base aligned to 1 MB, and a 4-bit code gives the window size as a power of two from 1 MB up to 2 GB. Every window maps onto local address zero, so the translated address is simply the offset of the incoming address inside the window.

Software loads a window by writing its configuration word with a window select. A lookup is presented as an address with a valid strobe; one clock later the block reports a valid flag, a hit flag, the winning window index and the translated local address. When windows overlap, the lowest-numbered window wins. A window holding a size code above the 2 GB code is treated as disabled.

Top module: `ibw_decoder`

## Requirements
- R1: After synchronous reset every window holds base 0 and size code 0xF (an illegal code), so no lookup hits until a window is written; res_valid and res_hit are 0 during and right after reset.
- R2: When cfg_we is 1 and cfg_sel is below 3, the window selected by cfg_sel takes base from cfg_wdata[31:20] and size code from cfg_wdata[19:16] at the clock edge; cfg_wdata[15:0] is ignored, and a write with cfg_sel of 3 changes no window.
- R3: Size code c in 0 to 11 gives a window of 2^(20+c) bytes (0 is 1 MB, 11 is 2 GB).
- R4: An address hits a window with a legal code c when its bits 31 down to 20+c equal the same bits of the stored base.
- R5: A window whose size code is 12 to 15 never hits.
- R6: When several windows hit, res_idx reports the lowest-numbered of them.
- R7: On a hit, res_local equals the incoming address with bits 31 down to 20+c cleared (local base zero).
- R8: res_valid is 1 exactly in the cycle after a cycle with lk_valid at 1; res_hit, res_idx and res_local belong to the lookup made in that earlier cycle.
- R9: A lookup that hits no window, or a cycle with no lookup, gives res_hit 0, res_idx 0 and res_local 0.
- R10: Stored base bits below the window size (bits 20+c-1 down to 20) take no part in the hit decision.
- R11: A lookup presented in the same cycle as a configuration write is decided with the window contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_sel | input | 2 | Window to write (0 to 2) |
| cfg_wdata | input | 32 | Configuration word: base in [31:20], size code in [19:16] |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Incoming bus address to decode |
| res_valid | output | 1 | Lookup result present (one cycle after request) |
| res_hit | output | 1 | Address fell into a window |
| res_idx | output | 2 | Index of the winning window |
| res_local | output | 32 | Translated local address |

## Verification
The bench goes after the window edges for the smallest and largest size, where an off-by-one in the size decode would either miss the last byte of a window or accept the first byte past it. It loads a base whose low bits lie inside the window size, which a design comparing the full base would wrongly reject, and sets illegal size codes that a design decoding them as very large windows would turn into spurious hits. Overlapping windows test that the lowest index wins rather than the highest, and a write issued alongside a lookup exposes a design that forwards the new contents into the pending decision; random configurations and addresses near each base cover the rest against a bench model.

// File: rtl/ibw_pkg.sv
package ibw_pkg;

    localparam int ADDR_W     = 32;
    localparam int WIN_COUNT  = 3;
    localparam int BASE_LSB   = 20;
    localparam int SIZE_LSB   = 16;
    localparam int SIZE_W     = 4;
    localparam int BASE_W     = ADDR_W - BASE_LSB;
    localparam int MAX_CODE   = 11;
    localparam logic [SIZE_W-1:0] CODE_OFF = 4'hF;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] code;
    } win_cfg_t;

    function automatic logic code_legal(input logic [SIZE_W-1:0] code);
        return int'(code) <= MAX_CODE;
    endfunction

    // Mask of the offset bits inside a window of the given size code.
    function automatic logic [ADDR_W-1:0] offset_mask(input logic [SIZE_W-1:0] code);
        logic [ADDR_W:0] one_hot;
        one_hot = (ADDR_W+1)'(1) << (BASE_LSB + int'(code));
        return ADDR_W'(one_hot - (ADDR_W+1)'(1));
    endfunction

endpackage

// File: rtl/ibw_win_regs.sv
module ibw_win_regs
    import ibw_pkg::*;
#(
    parameter int NUM_WIN = WIN_COUNT,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  sel,
    input  logic [ADDR_W-1:0] wdata,
    output win_cfg_t          cfg [NUM_WIN]
);

    logic unused_low_bits;
    assign unused_low_bits = ^wdata[SIZE_LSB-1:0];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[w] <= '{base: '0, code: CODE_OFF};
            end else if (we && int'(sel) == w) begin
                cfg[w] <= '{base: wdata[ADDR_W-1:BASE_LSB],
                            code: wdata[SIZE_LSB +: SIZE_W]};
            end
        end
    end

endmodule

// File: rtl/ibw_win_match.sv
module ibw_win_match
    import ibw_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] off_m;
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        off_m     = offset_mask(cfg.code);
        base_full = {cfg.base, {BASE_LSB{1'b0}}};
        hit       = code_legal(cfg.code) &&
                    ((addr & ~off_m) == (base_full & ~off_m));
        offset    = addr & off_m;
    end

endmodule

// File: rtl/ibw_prio_sel.sv
module ibw_prio_sel
    import ibw_pkg::*;
#(
    parameter int NUM_WIN = WIN_COUNT,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [NUM_WIN-1:0] hits,
    input  logic [ADDR_W-1:0] offsets [NUM_WIN],
    output logic              out_valid,
    output logic              out_hit,
    output logic [IDX_W-1:0]  out_idx,
    output logic [ADDR_W-1:0] out_local
);

    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    logic [ADDR_W-1:0] win_off;

    // Scan from the top down so the lowest index is the last to win.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        win_off = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
                win_off = offsets[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_idx   <= '0;
            out_local <= '0;
        end else begin
            out_valid <= req;
            out_hit   <= req && any_hit;
            out_idx   <= (req && any_hit) ? win_idx : '0;
            out_local <= (req && any_hit) ? win_off : '0;
        end
    end

endmodule

// File: rtl/ibw_decoder.sv
module ibw_decoder
    import ibw_pkg::*;
#(
    parameter int NUM_WIN = WIN_COUNT,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx,
    output logic [ADDR_W-1:0] res_local
);

    win_cfg_t          win_cfg [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    logic [ADDR_W-1:0] win_off [NUM_WIN];

    ibw_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (win_cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        ibw_win_match u_match (
            .cfg    (win_cfg[w]),
            .addr   (lk_addr),
            .hit    (win_hit[w]),
            .offset (win_off[w])
        );
    end

    ibw_prio_sel #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .req       (lk_valid),
        .hits      (win_hit),
        .offsets   (win_off),
        .out_valid (res_valid),
        .out_hit   (res_hit),
        .out_idx   (res_idx),
        .out_local (res_local)
    );

endmodule

// File: rtl/ibw_decoder_chk.sv
module ibw_decoder_chk
    import ibw_pkg::*;
#(
    parameter int NUM_WIN = WIN_COUNT,
    parameter int IDX_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              res_valid,
    input logic              res_hit,
    input logic [IDX_W-1:0]  res_idx,
    input logic [ADDR_W-1:0] res_local
);

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid); // R8
    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_idx == '0 && res_local == '0)); // R9
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid); // R8
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> int'(res_idx) < NUM_WIN); // R6
    AST_LOCAL_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> ((res_local & ~$past(lk_addr)) == '0)); // R7

endmodule

bind ibw_decoder ibw_decoder_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_idx   (res_idx),
    .res_local (res_local)
);

// File: tb/tb_ibw_decoder.sv
`timescale 1ns/1ps
module tb_ibw_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        res_valid;
    logic        res_hit;
    logic [1:0]  res_idx;
    logic [31:0] res_local;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_win [3];

    always #2 clk = ~clk;

    ibw_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_local(res_local)
    );

    function automatic logic [31:0] mk(input logic [31:0] base, input int code);
        return {base[31:20], 4'(code), 16'h0};
    endfunction

    function automatic void ref_lookup(input logic [31:0] a, output bit hit,
                                       output logic [1:0] idx, output logic [31:0] loc);
        hit = 0; idx = 0; loc = 0;
        for (int w = 0; w < 3; w++) begin
            int code;
            logic [63:0] m64;
            logic [31:0] msk;
            code = int'(m_win[w][19:16]);
            if (!hit && code <= 11) begin
                m64 = (64'h1 << (20 + code)) - 64'h1;
                msk = m64[31:0];
                if ((a & ~msk) == (m_win[w] & ~msk)) begin
                    hit = 1; idx = 2'(w); loc = a & msk;
                end
            end
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 0;
        if (sel < 3) m_win[sel] = data;
    endtask

    task automatic lookup(input logic [31:0] a, input string req);
        bit eh; logic [1:0] ei; logic [31:0] el;
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        ref_lookup(a, eh, ei, el);
        @(negedge clk);
        lk_valid = 0;
        check(res_valid == 1'b1, {req, " valid"}, 64'(res_valid), 64'd1);
        check(res_hit == eh, {req, " hit"}, 64'(res_hit), 64'(eh));
        check(res_idx == ei, {req, " idx"}, 64'(res_idx), 64'(ei));
        check(res_local == el, {req, " local"}, 64'(res_local), 64'(el));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; lk_valid = 0; lk_addr = 0;
        for (int w = 0; w < 3; w++) m_win[w] = 32'h000F_0000;
        repeat (3) @(negedge clk);
        check(res_valid == 0 && res_hit == 0, "R1 reset outputs", 64'({res_valid, res_hit}), 64'd0);
        rst = 0;
        // R1: nothing hits after reset, even address 0 (base 0)
        lookup(32'h0000_0000, "R1");
        lookup(32'h0001_2345, "R1");

        // R3/R4/R7: smallest window edges
        wr(0, mk(32'h1000_0000, 0));
        lookup(32'h1000_0000, "R3 1MB first");
        lookup(32'h100F_FFFF, "R3 1MB last");
        lookup(32'h1010_0000, "R4 1MB past end");
        lookup(32'h0FFF_FFFF, "R4 1MB below");
        // R3: largest window
        wr(1, mk(32'h8000_0000, 11));
        lookup(32'hFFFF_FFFF, "R3 2GB last");
        lookup(32'h7FFF_FFFF, "R4 2GB below");
        // R10: misaligned base 0x123 with 16MB window covers 0x12000000
        wr(2, mk(32'h1230_0000, 4));
        lookup(32'h1200_0005, "R10 low base bits ignored");
        lookup(32'h12FF_FFFF, "R7 16MB offset");
        // R2: low data bits ignored; sel 3 write ignored
        wr(2, mk(32'h2000_0000, 1) | 32'h0000_FFFF);
        lookup(32'h201F_FFFF, "R2 low bits ignored");
        wr(3, mk(32'h3000_0000, 0));
        lookup(32'h3000_0000, "R2 sel 3 ignored");
        // R5: illegal codes never hit
        for (int c = 12; c < 16; c++) begin
            wr(2, mk(32'h0000_0000, c));
            lookup(32'h0000_0010, "R5 illegal code");
        end
        // R6: overlap, lowest index wins
        wr(0, mk(32'h4000_0000, 2));
        wr(1, mk(32'h4000_0000, 6));
        wr(2, mk(32'h4000_0000, 8));
        lookup(32'h4010_0000, "R6 overlap win0");
        lookup(32'h4050_0000, "R6 overlap win1");
        lookup(32'h4500_0000, "R6 overlap win2");
        // R8/R9: no request gives no result
        @(negedge clk);
        lk_valid = 0; lk_addr = 32'h4010_0000;
        @(negedge clk);
        check(res_valid == 0 && res_hit == 0 && res_local == 0, "R8 R9 idle",
              64'({res_valid, res_hit, res_local}), 64'd0);
        // R11: lookup alongside write uses old contents
        @(negedge clk);
        cfg_we = 1; cfg_sel = 0; cfg_wdata = mk(32'h5000_0000, 0);
        lk_valid = 1; lk_addr = 32'h4000_0004;
        @(negedge clk);
        cfg_we = 0; lk_valid = 0;
        check(res_hit == 1 && res_idx == 0 && res_local == 32'h4, "R11 old contents",
              64'({res_hit, res_idx, res_local}), 64'({1'b1, 2'd0, 32'h4}));
        m_win[0] = mk(32'h5000_0000, 0);
        lookup(32'h4000_0004, "R11 new contents");

        // Random configurations and addresses
        for (int it = 0; it < 60; it++) begin
            for (int w = 0; w < 3; w++) wr(w, $urandom());
            for (int k = 0; k < 8; k++) begin
                logic [31:0] a;
                if (k[0]) a = {m_win[$urandom_range(0, 2)][31:20], 20'(0)} ^ ($urandom() >> $urandom_range(1, 31));
                else a = $urandom();
                lookup(a, "R4 R6 R7 random");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule